// File: doc/BRIEF.md
# Single-Channel Memory Copy Engine with Blanking and Audio-FIFO Triggers

This block is one channel of a memory copy engine. Software fills in a source address, a destination address, an element count and a control word. The channel then moves halfwords or words from source to destination over a request/ready memory port. Each element is one read followed by one write. The addresses step after each element by an amount that depends on a per-address adjustment code.

A 2-bit timing field in the control word chooses what starts a transfer:

- **Immediate:** the transfer starts as soon as the enable bit rises.
- **Vertical blank:** the transfer waits for a vertical-blank pulse.
- **Horizontal blank:** the transfer waits for a horizontal-blank pulse.
- **Audio FIFO:** on channels 1 and 2 only, the transfer waits for a sound request whose FIFO address equals the programmed destination. Each such request then moves a fixed burst of words into that FIFO, and the destination address stays put.

A repeating channel stays enabled once its count runs out and fires again at the next matching event. On that retrigger it reloads its count. If its destination uses the reload code, it also restores the programmed destination.

Top module: `dma_channel`

## Requirements
- R1: After reset, `mem_req` and `mem_we` are low and nothing starts until a register write or trigger arrives.
- R2: Registers are chosen by `reg_sel`: 0 source, 1 destination, 2 count, 3 control. The control word layout is: bits [1:0] destination code, [3:2] source code, [4] repeat, [5] word size (1 = 32-bit), [7:6] timing (00 immediate, 01 vertical blank, 10 horizontal blank, 11 audio FIFO), [15] enable. A control write that raises enable copies the programmed source, destination and count into the working registers, and timing 00 starts the transfer right away. A programmed count of 0 means 2^14 elements on the default channel (2^16 on channel 3).
- R3: Each element is a read at the working source followed by a write at the working destination. Each access holds its address and direction until `mem_ready` is sampled high. A word access sets `mem_be` to 4'b1111. A halfword access sets `mem_be` to 4'b0011 when address bit 1 is 0 and to 4'b1100 when it is 1. The halfword read from the source lane is written on the destination lane.
- R4: The address codes are 00 increment, 01 decrement and 10 fixed. Code 11 on the source leaves the source unchanged. The step is 2 bytes for halfwords and 4 bytes for words, and addresses wrap modulo 2^32.
- R5: Destination code 11 increments during a burst and restores the programmed destination when a repeating transfer is retriggered. Destination code 00 keeps counting on from where the last burst stopped.
- R6: A transfer stops requesting once its count reaches zero. If repeat is clear, the enable bit is also cleared, so later triggers are ignored. If repeat is set, the enable bit stays set.
- R7: A blank pulse starts the channel only when all of these hold: the channel is idle, it is enabled, and its timing is 01 for a vertical blank or 10 for a horizontal blank. Any other pulse, and any sound request to a channel not in timing 11, is ignored.
- R8: A repeating blank-timed transfer reloads its count from the programmed value each time it is retriggered.
- R9: In timing 11 the channel starts only when `snd_req` arrives with `snd_fifo_addr` equal to the programmed destination; a mismatched address is ignored. Each accepted request moves exactly 4 words (`mem_be` 4'b1111), whatever the size bit says. Every write goes to the same destination address. Repeat is forced on, so the next request is accepted again.
- R10: A control write with enable clear stops a running transfer, and no further accesses follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 src, 1 dst, 2 count, 3 control) |
| reg_wdata | input | 32 | Register write data |
| vblank_pulse | input | 1 | Vertical-blank event, one cycle |
| hblank_pulse | input | 1 | Horizontal-blank event, one cycle |
| snd_req | input | 1 | Sound FIFO refill request, one cycle |
| snd_fifo_addr | input | 32 | Address of the FIFO issuing the request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Access byte address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready on a read |
| mem_ready | input | 1 | Access completes on this cycle |

## Verification
The bound checker watches every cycle for four things:

- accesses are held stable while `mem_ready` is low;
- `mem_we` is never raised without a request, and a completed read is always followed by a write;
- byte enables are always a halfword pair or the full word, and they are always full in audio-FIFO mode;
- the channel never starts requesting unless a register write, a blank pulse or a sound request came first.

Some behaviours span many cycles and only the directed scenarios can show them:

- the address sequences for each adjustment code, including wrap-around;
- the zero-count maximum;
- the destination reload on a repeat retrigger;
- the enable bit clearing at the end of a non-repeating transfer;
- the FIFO address match and the fixed 4-word burst.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic [1:0] {
        ADJ_INC = 2'b00,
        ADJ_DEC = 2'b01,
        ADJ_FIX = 2'b10,
        ADJ_RLD = 2'b11
    } adj_e;

    typedef enum logic [1:0] {
        TM_NOW  = 2'b00,
        TM_VBL  = 2'b01,
        TM_HBL  = 2'b10,
        TM_FIFO = 2'b11
    } tmode_e;

    typedef struct packed {
        logic   enable;
        tmode_e timing;
        logic   word;
        logic   rpt;
        adj_e   src_adj;
        adj_e   dst_adj;
    } ctrl_t;

    localparam logic [1:0] SEL_SRC  = 2'd0;
    localparam logic [1:0] SEL_DST  = 2'd1;
    localparam logic [1:0] SEL_CNT  = 2'd2;
    localparam logic [1:0] SEL_CTRL = 2'd3;

    localparam int CTRL_W = 16;

    function automatic ctrl_t ctrl_decode(input logic [CTRL_W-1:0] w);
        ctrl_t c;
        c.dst_adj = adj_e'(w[1:0]);
        c.src_adj = adj_e'(w[3:2]);
        c.rpt     = w[4];
        c.word    = w[5];
        c.timing  = tmode_e'(w[7:6]);
        c.enable  = w[15];
        return c;
    endfunction

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter bit IS_SRC = 1'b0
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  adj_e              mode_i,
    input  logic              word_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam logic [ADDR_W-1:0] STEP_HALF = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] STEP_WORD = ADDR_W'(4);

    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] rld_next;

    assign step = word_i ? STEP_WORD : STEP_HALF;

    // Code 11 has no meaning on the source side: hold the address.
    generate
        if (IS_SRC) begin : g_src_rld
            assign rld_next = addr_i;
        end else begin : g_dst_rld
            assign rld_next = addr_i + step;
        end
    endgenerate

    always_comb begin
        unique case (mode_i)
            ADJ_INC: addr_o = addr_i + step;
            ADJ_DEC: addr_o = addr_i - step;
            ADJ_FIX: addr_o = addr_i;
            default: addr_o = rld_next;
        endcase
    end

endmodule

// File: rtl/dma_lane.sv
module dma_lane #(
    parameter int DATA_W = 32
) (
    input  logic                word_i,
    input  logic                src_hi_i,
    input  logic                cur_hi_i,
    input  logic [DATA_W-1:0]   data_i,
    output logic [DATA_W/8-1:0] be_o,
    output logic [DATA_W-1:0]   wdata_o
);
    localparam int HALF_W = DATA_W / 2;
    localparam int BE_W   = DATA_W / 8;
    localparam logic [BE_W-1:0] BE_LO = {{(BE_W/2){1'b0}}, {(BE_W/2){1'b1}}};
    localparam logic [BE_W-1:0] BE_HI = {{(BE_W/2){1'b1}}, {(BE_W/2){1'b0}}};

    logic [HALF_W-1:0] half;

    assign half    = src_hi_i ? data_i[DATA_W-1:HALF_W] : data_i[HALF_W-1:0];
    assign wdata_o = word_i ? data_i : {half, half};
    assign be_o    = word_i ? {BE_W{1'b1}} : (cur_hi_i ? BE_HI : BE_LO);

endmodule

// File: rtl/dma_trigger.sv
module dma_trigger
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter bit FIFO_OK = 1'b1
) (
    input  ctrl_t             ctrl_i,
    input  logic              active_i,
    input  logic              vblank_i,
    input  logic              hblank_i,
    input  logic              snd_req_i,
    input  logic [ADDR_W-1:0] snd_addr_i,
    input  logic [ADDR_W-1:0] dst_prog_i,
    output logic              blank_go_o,
    output logic              fifo_go_o
);
    logic blank_hit;

    assign blank_hit  = (vblank_i && ctrl_i.timing == TM_VBL) ||
                        (hblank_i && ctrl_i.timing == TM_HBL);
    assign blank_go_o = !active_i && ctrl_i.enable && blank_hit;

    generate
        if (FIFO_OK) begin : g_fifo
            assign fifo_go_o = snd_req_i && ctrl_i.enable &&
                               ctrl_i.timing == TM_FIFO &&
                               snd_addr_i == dst_prog_i;
        end else begin : g_nofifo
            assign fifo_go_o = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/dma_channel.sv
module dma_channel
    import dma_chan_pkg::*;
#(
    parameter int CHAN_ID    = 1,
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int FIFO_BURST = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr_en,
    input  logic [1:0]          reg_sel,
    input  logic [ADDR_W-1:0]   reg_wdata,
    input  logic                vblank_pulse,
    input  logic                hblank_pulse,
    input  logic                snd_req,
    input  logic [ADDR_W-1:0]   snd_fifo_addr,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W/8-1:0] mem_be,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata,
    input  logic                mem_ready
);
    localparam bit FIFO_OK  = (CHAN_ID == 1) || (CHAN_ID == 2);
    localparam int CNT_BITS = (CHAN_ID == 3) ? 16 : 14;
    localparam int CNT_W    = CNT_BITS + 1;
    localparam int BE_W     = DATA_W / 8;
    localparam logic [CNT_W-1:0] CNT_MAX = {1'b1, {CNT_BITS{1'b0}}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0]   src_prog;
        logic [ADDR_W-1:0]   dst_prog;
        logic [CNT_BITS-1:0] cnt_prog;
        logic [ADDR_W-1:0]   src;
        logic [ADDR_W-1:0]   dst;
        logic [CNT_W-1:0]    cnt;
        ctrl_t               ctrl;
        logic                active;
        logic                wr_phase;
        logic [DATA_W-1:0]   data;
    } st_t;

    st_t q, d;

    logic              is_fifo;
    logic              word_eff;
    logic [ADDR_W-1:0] src_nx;
    logic [ADDR_W-1:0] dst_nx;
    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  load_cnt;
    logic              blank_go;
    logic              fifo_go;
    ctrl_t             new_ctrl;

    assign is_fifo  = FIFO_OK && (q.ctrl.timing == TM_FIFO);
    assign word_eff = q.ctrl.word || is_fifo;
    assign cur_addr = q.wr_phase ? q.dst : q.src;
    assign load_cnt = (q.cnt_prog == '0) ? CNT_MAX : CNT_W'(q.cnt_prog);
    assign new_ctrl = ctrl_decode(reg_wdata[CTRL_W-1:0]);

    dma_addr_step #(.ADDR_W(ADDR_W), .IS_SRC(1'b1)) u_src_step (
        .addr_i (q.src),
        .mode_i (q.ctrl.src_adj),
        .word_i (word_eff),
        .addr_o (src_nx)
    );

    dma_addr_step #(.ADDR_W(ADDR_W), .IS_SRC(1'b0)) u_dst_step (
        .addr_i (q.dst),
        .mode_i (q.ctrl.dst_adj),
        .word_i (word_eff),
        .addr_o (dst_nx)
    );

    dma_trigger #(.ADDR_W(ADDR_W), .FIFO_OK(FIFO_OK)) u_trig (
        .ctrl_i     (q.ctrl),
        .active_i   (q.active),
        .vblank_i   (vblank_pulse),
        .hblank_i   (hblank_pulse),
        .snd_req_i  (snd_req),
        .snd_addr_i (snd_fifo_addr),
        .dst_prog_i (q.dst_prog),
        .blank_go_o (blank_go),
        .fifo_go_o  (fifo_go)
    );

    dma_lane #(.DATA_W(DATA_W)) u_lane (
        .word_i   (word_eff),
        .src_hi_i (q.src[1]),
        .cur_hi_i (cur_addr[1]),
        .data_i   (q.data),
        .be_o     (mem_be),
        .wdata_o  (mem_wdata)
    );

    assign mem_req  = q.active;
    assign mem_we   = q.active && q.wr_phase;
    assign mem_addr = cur_addr;

    always_comb begin
        d = q;

        // Bus sequencing: read phase captures data, write phase advances state.
        if (q.active && mem_ready) begin
            if (!q.wr_phase) begin
                d.data     = mem_rdata;
                d.wr_phase = 1'b1;
            end else begin
                d.wr_phase = 1'b0;
                d.src      = src_nx;
                if (!is_fifo) begin
                    d.dst = dst_nx;
                end
                d.cnt = q.cnt - CNT_ONE;
                if (q.cnt == CNT_ONE) begin
                    d.active = 1'b0;
                    if (!q.ctrl.rpt) begin
                        d.ctrl.enable = 1'b0;
                    end
                end
            end
        end

        // Blank-timed start, with reload on repeat.
        if (blank_go) begin
            d.active = 1'b1;
            if (q.ctrl.rpt) begin
                d.cnt = load_cnt;
                if (q.ctrl.dst_adj == ADJ_RLD) begin
                    d.dst = q.dst_prog;
                end
            end
        end

        // Audio FIFO refill burst.
        if (fifo_go) begin
            d.active   = 1'b1;
            d.cnt      = CNT_W'(FIFO_BURST);
            d.ctrl.rpt = 1'b1;
        end

        // Register writes take priority.
        if (reg_wr_en) begin
            unique case (reg_sel)
                SEL_SRC: d.src_prog = reg_wdata;
                SEL_DST: d.dst_prog = reg_wdata;
                SEL_CNT: d.cnt_prog = reg_wdata[CNT_BITS-1:0];
                default: begin
                    d.ctrl = new_ctrl;
                    if (new_ctrl.enable && !q.ctrl.enable) begin
                        d.src      = q.src_prog;
                        d.dst      = q.dst_prog;
                        d.cnt      = load_cnt;
                        d.active   = (new_ctrl.timing == TM_NOW);
                        d.wr_phase = 1'b0;
                    end else if (!new_ctrl.enable) begin
                        d.active   = 1'b0;
                        d.wr_phase = 1'b0;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/dma_channel_chk.sv
module dma_channel_chk #(
    parameter int ADDR_W = 32,
    parameter int BE_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [BE_W-1:0]   mem_be,
    input logic              reg_wr_en,
    input logic              vblank_pulse,
    input logic              hblank_pulse,
    input logic              snd_req,
    input logic              is_fifo
);
    // R3
    we_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);

    // R3
    hold_until_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready && !reg_wr_en |=>
            mem_req && $stable(mem_addr) && $stable(mem_we));

    // R3
    read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ready && !mem_we && !reg_wr_en |=> mem_req && mem_we);

    // R3
    be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ($countones(mem_be) == BE_W / 2 || mem_be == {BE_W{1'b1}}));

    // R9
    fifo_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && is_fifo |-> mem_be == {BE_W{1'b1}});

    // R7
    no_spurious_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_req && !vblank_pulse && !hblank_pulse && !snd_req && !reg_wr_en |=> !mem_req);

endmodule

bind dma_channel dma_channel_chk #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_ready    (mem_ready),
    .mem_addr     (mem_addr),
    .mem_be       (mem_be),
    .reg_wr_en    (reg_wr_en),
    .vblank_pulse (vblank_pulse),
    .hblank_pulse (hblank_pulse),
    .snd_req      (snd_req),
    .is_fifo      (is_fifo)
);

// File: tb/tb_dma_channel.sv
module tb_dma_channel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic        vblank_pulse = 1'b0;
    logic        hblank_pulse = 1'b0;
    logic        snd_req = 1'b0;
    logic [31:0] snd_fifo_addr = '0;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        mem_ready;

    logic ws_mode = 1'b0;
    int   cyc = 0;

    int n_checks = 0;
    int n_fail   = 0;
    int wr_total = 0;

    logic [31:0] log_addr [256];
    logic [3:0]  log_be   [256];
    logic [31:0] log_data [256];

    localparam logic [31:0] FIFO_X = 32'h0000_0F00;
    localparam logic [31:0] FIFO_Y = 32'h0000_0F04;

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] fmem(input logic [31:0] a);
        return {a[31:2], 2'b00} ^ 32'h5A0F_00C3;
    endfunction

    assign mem_rdata = fmem(mem_addr);
    assign mem_ready = ws_mode ? (cyc % 3 == 2) : 1'b1;

    dma_channel dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr_en     (reg_wr_en),
        .reg_sel       (reg_sel),
        .reg_wdata     (reg_wdata),
        .vblank_pulse  (vblank_pulse),
        .hblank_pulse  (hblank_pulse),
        .snd_req       (snd_req),
        .snd_fifo_addr (snd_fifo_addr),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_be        (mem_be),
        .mem_wdata     (mem_wdata),
        .mem_rdata     (mem_rdata),
        .mem_ready     (mem_ready)
    );

    always @(negedge clk) begin
        if (mem_req && mem_we && mem_ready) begin
            if (wr_total < 256) begin
                log_addr[wr_total] = mem_addr;
                log_be[wr_total]   = mem_be;
                log_data[wr_total] = mem_wdata;
            end
            wr_total = wr_total + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] cw(input bit en, input logic [1:0] tm, input bit word,
                                       input bit rpt, input logic [1:0] sadj,
                                       input logic [1:0] dadj);
        return {16'h0, en, 7'h0, tm, word, rpt, sadj, dadj};
    endfunction

    task automatic wr_reg(input logic [1:0] s, input logic [31:0] v);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_sel   = s;
        reg_wdata = v;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic setup(input logic [31:0] src, input logic [31:0] dst, input logic [31:0] cnt);
        wr_reg(2'd3, 32'h0);
        wr_reg(2'd0, src);
        wr_reg(2'd1, dst);
        wr_reg(2'd2, cnt);
    endtask

    task automatic pulse_vbl();
        @(negedge clk); vblank_pulse = 1'b1;
        @(negedge clk); vblank_pulse = 1'b0;
    endtask

    task automatic pulse_hbl();
        @(negedge clk); hblank_pulse = 1'b1;
        @(negedge clk); hblank_pulse = 1'b0;
    endtask

    task automatic pulse_snd(input logic [31:0] a);
        @(negedge clk); snd_req = 1'b1; snd_fifo_addr = a;
        @(negedge clk); snd_req = 1'b0;
    endtask

    task automatic wait_idle();
        int t = 0;
        @(negedge clk);
        while (mem_req && t < 100000) begin
            @(negedge clk);
            t++;
        end
        chk(t < 100000, "R6", "transfer finished", 32'(t), 32'd100000);
    endtask

    task automatic idle_for(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_wr(input int idx, input logic [31:0] exp_addr,
                            input logic [31:0] src, input bit word, input string req);
        logic [31:0] f, exp, mask;
        logic [3:0]  be;
        logic [15:0] h;
        f = fmem(src);
        if (word) begin
            exp = f; be = 4'hF; mask = 32'hFFFF_FFFF;
        end else begin
            h    = src[1] ? f[31:16] : f[15:0];
            exp  = {h, h};
            be   = exp_addr[1] ? 4'b1100 : 4'b0011;
            mask = exp_addr[1] ? 32'hFFFF_0000 : 32'h0000_FFFF;
        end
        chk(log_addr[idx] == exp_addr, req, "write address", log_addr[idx], exp_addr);
        chk(log_be[idx] == be, req, "byte enables", 32'(log_be[idx]), 32'(be));
        chk((log_data[idx] & mask) == (exp & mask), req, "write data",
            log_data[idx] & mask, exp & mask);
    endtask

    task automatic t_reset();
        chk(mem_req == 1'b0, "R1", "req after reset", 32'(mem_req), 32'd0);
        chk(mem_we == 1'b0, "R1", "we after reset", 32'(mem_we), 32'd0);
        idle_for(4);
        chk(wr_total == 0, "R1", "no writes while idle", 32'(wr_total), 32'd0);
    endtask

    task automatic t_imm_word_inc();
        int b;
        setup(32'h0000_1000, 32'h0000_2000, 32'd3);
        b = wr_total;
        wr_reg(2'd3, cw(1, 2'b00, 1, 0, 2'b00, 2'b00));
        chk(mem_req == 1'b1, "R2", "immediate start", 32'(mem_req), 32'd1);
        wait_idle();
        chk(wr_total - b == 3, "R2", "element count", 32'(wr_total - b), 32'd3);
        for (int i = 0; i < 3; i++)
            check_wr(b + i, 32'h2000 + 32'(4 * i), 32'h1000 + 32'(4 * i), 1, "R4");
    endtask

    task automatic t_half_dec();
        int b;
        setup(32'h0000_3002, 32'h0000_4006, 32'd3);
        b = wr_total;
        wr_reg(2'd3, cw(1, 2'b00, 0, 0, 2'b01, 2'b01));
        wait_idle();
        chk(wr_total - b == 3, "R3", "halfword count", 32'(wr_total - b), 32'd3);
        for (int i = 0; i < 3; i++)
            check_wr(b + i, 32'h4006 - 32'(2 * i), 32'h3002 - 32'(2 * i), 0, "R3");
    endtask

    task automatic t_fixed_src_rld();
        int b;
        setup(32'h0000_1100, 32'h0000_5000, 32'd2);
        b = wr_total;
        wr_reg(2'd3, cw(1, 2'b00, 1, 0, 2'b11, 2'b10));
        wait_idle();
        for (int i = 0; i < 2; i++)
            check_wr(b + i, 32'h5000, 32'h1100, 1, "R4");
    endtask

    task automatic t_wrap();
        int b;
        setup(32'hFFFF_FFFC, 32'h0000_6000, 32'd2);
        b = wr_total;
        wr_reg(2'd3, cw(1, 2'b00, 1, 0, 2'b00, 2'b00));
        wait_idle();
        check_wr(b, 32'h6000, 32'hFFFF_FFFC, 1, "R4");
        check_wr(b + 1, 32'h6004, 32'h0000_0000, 1, "R4");
    endtask

    task automatic t_waitstates();
        int b;
        ws_mode = 1'b1;
        setup(32'h0000_1300, 32'h0000_6100, 32'd2);
        b = wr_total;
        wr_reg(2'd3, cw(1, 2'b00, 1, 0, 2'b00, 2'b00));
        wait_idle();
        ws_mode = 1'b0;
        chk(wr_total - b == 2, "R3", "count with wait states", 32'(wr_total - b), 32'd2);
        check_wr(b, 32'h6100, 32'h1300, 1, "R3");
        check_wr(b + 1, 32'h6104, 32'h1304, 1, "R3");
    endtask

    task automatic t_vbl_once();
        int b;
        setup(32'h0000_1400, 32'h0000_6200, 32'd2);
        wr_reg(2'd3, cw(1, 2'b01, 1, 0, 2'b00, 2'b00));
        idle_for(3);
        chk(mem_req == 1'b0, "R7", "waits for vblank", 32'(mem_req), 32'd0);
        b = wr_total;
        pulse_vbl();
        wait_idle();
        chk(wr_total - b == 2, "R7", "vblank burst", 32'(wr_total - b), 32'd2);
        check_wr(b + 1, 32'h6204, 32'h1404, 1, "R7");
        b = wr_total;
        pulse_vbl();
        idle_for(4);
        chk(wr_total - b == 0, "R6", "enable cleared without repeat", 32'(wr_total - b), 32'd0);
    endtask

    task automatic t_hbl_match();
        int b;
        setup(32'h0000_1500, 32'h0000_6300, 32'd2);
        wr_reg(2'd3, cw(1, 2'b10, 1, 0, 2'b00, 2'b00));
        b = wr_total;
        pulse_vbl();
        pulse_snd(32'h0000_6300);
        idle_for(4);
        chk(wr_total - b == 0, "R7", "wrong event ignored", 32'(wr_total - b), 32'd0);
        chk(mem_req == 1'b0, "R7", "still idle", 32'(mem_req), 32'd0);
        pulse_hbl();
        wait_idle();
        chk(wr_total - b == 2, "R7", "hblank burst", 32'(wr_total - b), 32'd2);
        check_wr(b, 32'h6300, 32'h1500, 1, "R7");
    endtask

    task automatic t_repeat(input logic [1:0] dadj, input logic [31:0] exp_second_dst);
        int b;
        setup(32'h0000_1200, 32'h0000_7000, 32'd2);
        wr_reg(2'd3, cw(1, 2'b01, 1, 1, 2'b00, dadj));
        b = wr_total;
        pulse_vbl();
        wait_idle();
        chk(wr_total - b == 2, "R8", "first repeat burst", 32'(wr_total - b), 32'd2);
        check_wr(b + 1, 32'h7004, 32'h1204, 1, "R5");
        b = wr_total;
        pulse_vbl();
        wait_idle();
        chk(wr_total - b == 2, "R8", "count reloaded", 32'(wr_total - b), 32'd2);
        check_wr(b, exp_second_dst, 32'h1208, 1, "R5");
        wr_reg(2'd3, 32'h0);
    endtask

    task automatic t_fifo();
        int b;
        setup(32'h0000_8000, FIFO_X, 32'd17);
        wr_reg(2'd3, cw(1, 2'b11, 0, 0, 2'b00, 2'b00));
        idle_for(3);
        chk(mem_req == 1'b0, "R9", "no immediate start", 32'(mem_req), 32'd0);
        b = wr_total;
        pulse_snd(FIFO_Y);
        idle_for(4);
        chk(wr_total - b == 0, "R9", "mismatched fifo ignored", 32'(wr_total - b), 32'd0);
        pulse_snd(FIFO_X);
        wait_idle();
        chk(wr_total - b == 4, "R9", "burst of 4", 32'(wr_total - b), 32'd4);
        for (int i = 0; i < 4; i++)
            check_wr(b + i, FIFO_X, 32'h8000 + 32'(4 * i), 1, "R9");
        b = wr_total;
        pulse_snd(FIFO_X);
        wait_idle();
        chk(wr_total - b == 4, "R9", "second request accepted", 32'(wr_total - b), 32'd4);
        check_wr(b, FIFO_X, 32'h8010, 1, "R9");
        wr_reg(2'd3, 32'h0);
    endtask

    task automatic t_disable();
        int b, mid;
        setup(32'h0000_9000, 32'h0000_A000, 32'd10);
        b = wr_total;
        wr_reg(2'd3, cw(1, 2'b00, 1, 0, 2'b00, 2'b00));
        idle_for(4);
        wr_reg(2'd3, cw(0, 2'b00, 1, 0, 2'b00, 2'b00));
        idle_for(2);
        chk(mem_req == 1'b0, "R10", "stopped by disable", 32'(mem_req), 32'd0);
        mid = wr_total - b;
        chk(mid > 0 && mid < 10, "R10", "partial transfer", 32'(mid), 32'd5);
        idle_for(10);
        chk(wr_total - b == mid, "R10", "no accesses after disable", 32'(wr_total - b), 32'(mid));
    endtask

    task automatic t_count_zero();
        int b;
        setup(32'h0000_B000, 32'h0000_C000, 32'd0);
        b = wr_total;
        wr_reg(2'd3, cw(1, 2'b00, 1, 0, 2'b10, 2'b10));
        wait_idle();
        chk(wr_total - b == 16384, "R2", "zero count means maximum", 32'(wr_total - b), 32'd16384);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        idle_for(2);
        t_reset();
        t_imm_word_inc();
        t_half_dec();
        t_fixed_src_rld();
        t_wrap();
        t_waitstates();
        t_vbl_once();
        t_hbl_match();
        t_repeat(2'b11, 32'h0000_7000);
        t_repeat(2'b00, 32'h0000_7008);
        t_fifo();
        t_disable();
        t_count_zero();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule